// File: doc/BRIEF.md
# Four-Stage Load, Shift and Rotate Register

This block is a small register of four stages, first to last, that either captures a parallel word or moves its contents one place toward the last stage on each rising clock edge. The mode input chooses between the two: low captures, high shifts. During a shift the new value of the first stage comes from a pair of serial inputs. One is active high (`j_in`) and one is active low (`kbar_in`), and together they can set, clear, toggle or hold that stage. Tying the two together gives a plain data-type serial input.

The last stage drives the serial output, and all four stages are visible on the parallel output. A right rotation comes from feeding the serial output back into the serial inputs. The `rot_en` input does the same feedback inside the block: in shift mode it overrides the serial pair. An active-low clear empties every stage at once without waiting for the clock, and it wins over both load and shift. The stage count is a parameter with a default of four.

Top module: `bit_shift_reg`

## Requirements
- R1: While `clr_n` is low, every bit of `par_out` is 0 at once, with no clock edge needed.
- R2: On a rising edge with `clr_n` high and `mode_shift` = 0, `par_out` takes the value `par_in`. Bit WIDTH-1 is the first stage and bit 0 is the last stage.
- R3: On a rising edge with `mode_shift` = 1, each stage takes the old value of the stage before it, moving from bit k+1 to bit k. Loading 1011 and then shifting with a 0 entering gives 0101, 0010, 0001, 0000.
- R4: In shift mode with `rot_en` = 0, `j_in`=1 and `kbar_in`=1 put a 1 into the first stage, and `j_in`=0 and `kbar_in`=0 put a 0 into it.
- R5: In shift mode with `rot_en` = 0, `j_in`=1 and `kbar_in`=0 make the first stage take the inverse of its old value, and `j_in`=0 and `kbar_in`=1 make it keep its old value.
- R6: In shift mode with `rot_en` = 1, the first stage takes the old last stage whatever the serial pair holds. Loading 1011 gives 1101, 1110, 0111, 1011.
- R7: `par_in` has no effect in shift mode, and `rot_en`, `j_in` and `kbar_in` have no effect in load mode.
- R8: A clock edge while `clr_n` is low leaves `par_out` at 0, even in load mode with a non-zero `par_in`.
- R9: `ser_out` always equals `par_out[0]`, the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_shift | input | 1 | 0 = parallel load, 1 = shift toward last stage |
| j_in | input | 1 | Serial entry, active-high half of the pair |
| kbar_in | input | 1 | Serial entry, active-low half of the pair |
| rot_en | input | 1 | In shift mode, feed the last stage into the first |
| par_in | input | WIDTH | Parallel data; bit WIDTH-1 goes to the first stage |
| par_out | output | WIDTH | All stages; bit WIDTH-1 is the first stage |
| ser_out | output | 1 | Last stage |

## Verification
The clocked assertions assume that `mode_shift`, `rot_en`, the serial pair and `par_in` are stable and known around each rising edge. They also assume that `clr_n` does not change on a clock edge. The bench drives every input half a period away from the rising edge, so the sampled values match what the flops capture. It also releases and asserts the clear mid-cycle, which keeps the asynchronous path apart from the edge checks. The clear check holds no matter what the other inputs do.

// File: rtl/bit_shift_pkg.sv
// Package: shared mode encoding for the load/shift register.
// Assumes: nothing; types only.
package bit_shift_pkg;
    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } op_mode_t;
endpackage

// File: rtl/bit_shift_head.sv
// Module: first-stage entry logic. Computes the value that enters the
// first stage during a shift, from the serial pair or from the rotate path.
// Assumes: cur_head is the current first stage and cur_tail the last stage.
module bit_shift_head (
    input  logic j_in,
    input  logic kbar_in,
    input  logic rot_en,
    input  logic cur_head,
    input  logic cur_tail,
    output logic next_head
);
    logic jk_val;

    // Serial-pair behaviour: set, clear, toggle or hold the first stage.
    always_comb begin
        jk_val = (j_in & ~cur_head) | (kbar_in & cur_head);
    end

    // The rotate path takes over from the serial pair.
    always_comb begin
        next_head = rot_en ? cur_tail : jk_val;
    end
endmodule

// File: rtl/bit_shift_core.sv
// Module: stage storage with per-stage load/shift selection.
// Assumes: bit WIDTH-1 is the first stage; clear is asynchronous, active low.
module bit_shift_core #(
    parameter int WIDTH = 4
) (
    input  logic                    clk,
    input  logic                    clr_n,
    input  bit_shift_pkg::op_mode_t mode,
    input  logic                    head_in,
    input  logic [WIDTH-1:0]        par_in,
    output logic [WIDTH-1:0]        q
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] d;

    // Per-stage next-value selection; the first stage takes the head value.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == TOP) begin : g_first
            always_comb begin
                d[i] = (mode == bit_shift_pkg::MODE_LOAD) ? par_in[i] : head_in;
            end
        end else begin : g_rest
            always_comb begin
                d[i] = (mode == bit_shift_pkg::MODE_LOAD) ? par_in[i] : q[i+1];
            end
        end
    end

    // Stage flops: asynchronous clear first, then capture on the clock.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/bit_shift_reg.sv
// Module: top of the load/shift/rotate register.
// Assumes: inputs are stable around rising edges; clr_n does not change
// on a clock edge.
module bit_shift_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             mode_shift,
    input  logic             j_in,
    input  logic             kbar_in,
    input  logic             rot_en,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_out
);
    localparam int TOP = WIDTH - 1;

    bit_shift_pkg::op_mode_t mode;
    logic                    head_val;
    logic [WIDTH-1:0]        q;

    // Map the mode pin onto the shared encoding.
    always_comb begin
        mode = mode_shift ? bit_shift_pkg::MODE_SHIFT : bit_shift_pkg::MODE_LOAD;
    end

    bit_shift_head u_head (
        .j_in      (j_in),
        .kbar_in   (kbar_in),
        .rot_en    (rot_en),
        .cur_head  (q[TOP]),
        .cur_tail  (q[0]),
        .next_head (head_val)
    );

    bit_shift_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .clr_n   (clr_n),
        .mode    (mode),
        .head_in (head_val),
        .par_in  (par_in),
        .q       (q)
    );

    // Drive the outputs from the stage flops.
    always_comb begin
        par_out = q;
        ser_out = q[0];
    end

    AST_CLEAR_EMPTY: assert property (@(posedge clk) !clr_n |-> par_out == '0); // R1
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
        !mode_shift |=> par_out == $past(par_in)); // R2
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
        mode_shift |=> par_out[TOP-1:0] == $past(par_out[TOP:1])); // R3
    AST_JK_SET: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_shift && !rot_en && j_in && kbar_in) |=> par_out[TOP]); // R4
    AST_JK_CLEAR: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_shift && !rot_en && !j_in && !kbar_in) |=> !par_out[TOP]); // R4
    AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_shift && !rot_en && j_in && !kbar_in) |=> par_out[TOP] != $past(par_out[TOP])); // R5
    AST_JK_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_shift && !rot_en && !j_in && kbar_in) |=> $stable(par_out[TOP])); // R5
    AST_ROT_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_shift && rot_en) |=> par_out[TOP] == $past(ser_out)); // R6
endmodule

// File: tb/sim_bit_shift_reg.sv
module sim_bit_shift_reg;
    localparam int PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         mode_shift = 1'b0;
    logic         j_in = 1'b0;
    logic         kbar_in = 1'b0;
    logic         rot_en = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] par_out;
    logic         ser_out;

    int n_run = 0;
    int n_fail = 0;
    int model [W];   // model[0] = first stage, model[W-1] = last stage

    bit_shift_reg #(.WIDTH(W)) u0 (
        .clk(clk), .clr_n(clr_n), .mode_shift(mode_shift), .j_in(j_in),
        .kbar_in(kbar_in), .rot_en(rot_en), .par_in(par_in),
        .par_out(par_out), .ser_out(ser_out)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] model_word();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[W-1-i] = model[i][0];
        return v;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, par_out, model_word());
        check("R9 serial output", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, model_word()[0]});
    endtask

    // One clock: inputs already set at negedge; update model at the edge, compare after.
    task automatic clock_step(input string tag);
        int tail;
        int head;
        @(posedge clk);
        if (!clr_n) begin
            for (int i = 0; i < W; i++) model[i] = 0;
        end else if (!mode_shift) begin
            for (int i = 0; i < W; i++) model[i] = int'(par_in[W-1-i]);
        end else begin
            tail = model[W-1];
            if (rot_en) head = tail;
            else if (j_in && kbar_in) head = 1;
            else if (!j_in && !kbar_in) head = 0;
            else if (j_in) head = 1 - model[0];
            else head = model[0];
            for (int i = W-1; i > 0; i--) model[i] = model[i-1];
            model[0] = head;
        end
        #(PERIOD/4);
        check_all(tag);
        @(negedge clk);
    endtask

    task automatic drive(input logic m, input logic j, input logic kb, input logic r, input logic [W-1:0] p);
        mode_shift = m; j_in = j; kbar_in = kb; rot_en = r; par_in = p;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] lf;
        for (int i = 0; i < W; i++) model[i] = 0;
        #(PERIOD/4);
        check_all("R1 reset state");
        @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);

        // R2: load 1011
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'b1011);
        clock_step("R2 load 1011");
        check("R2 load value", par_out, 4'b1011);

        // R3 / R4: shift with a 0 entering
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'b1111);
        clock_step("R3 shift 1"); check("R3 seq", par_out, 4'b0101);
        clock_step("R3 shift 2"); check("R3 seq", par_out, 4'b0010);
        clock_step("R3 shift 3"); check("R3 seq", par_out, 4'b0001);
        clock_step("R4 clear entry"); check("R3 seq", par_out, 4'b0000);

        // R6: rotate overriding serial pair; R7 par_in ignored while shifting
        drive(1'b0, 1'b0, 1'b0, 1'b0, 4'b1011);
        clock_step("R2 reload");
        drive(1'b1, 1'b0, 1'b0, 1'b1, 4'b0000);
        clock_step("R6 rot 1"); check("R6 seq", par_out, 4'b1101);
        clock_step("R6 rot 2"); check("R6 seq", par_out, 4'b1110);
        clock_step("R6 rot 3"); check("R6 seq", par_out, 4'b0111);
        clock_step("R6 rot 4"); check("R6 seq", par_out, 4'b1011);

        // R4 set, R5 toggle and hold
        drive(1'b0, 1'b0, 1'b0, 1'b0, 4'b0000);
        clock_step("R2 load zero");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 4'b1111);
        clock_step("R4 set entry"); check("R4 set", par_out, 4'b1000);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 4'b0000);
        clock_step("R5 toggle 1"); check("R5 toggle", par_out, 4'b0100);
        clock_step("R5 toggle 2"); check("R5 toggle", par_out, 4'b1010);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 4'b0101);
        clock_step("R5 hold"); check("R5 hold", par_out, 4'b1101);

        // R7: rotate/serial ignored in load mode
        drive(1'b0, 1'b1, 1'b0, 1'b1, 4'b0110);
        clock_step("R7 load ignores rot"); check("R7 load", par_out, 4'b0110);

        // R1: asynchronous clear mid-cycle, no edge
        #(PERIOD/4);
        clr_n = 1'b0;
        for (int i = 0; i < W; i++) model[i] = 0;
        #1;
        check("R1 async clear", par_out, 4'b0000);
        @(negedge clk);
        // R8: clear wins over load
        drive(1'b0, 1'b0, 1'b0, 1'b0, 4'b1111);
        clock_step("R8 clear over load"); check("R8 clear", par_out, 4'b0000);
        #(PERIOD/4);
        clr_n = 1'b1;
        @(negedge clk);

        // Mixed stimulus against the model
        lf = 8'hA5;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            drive(lf[0] | lf[7], lf[1], lf[2], lf[3] & lf[6], lf[7:4]);
            clock_step("R7 mixed");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule